// File: doc/BRIEF.md
# Lockable Flash Line Cache

This block sits between a processor fetch port and a slow flash memory. It keeps sixteen 128-bit lines (256 bytes in total), each holding four 32-bit words. A hit returns the addressed word one cycle after the request is taken. On a miss the block presents a line address to the flash and holds it for a programmable number of wait states. It then captures the whole 128-bit line, returns the requested word and, when a victim line is available, stores the line.

Lookup is fully associative. A programmable mask removes chosen line-address bits from the tag compare, so that identical copies of code at several addresses share one line. Lines 0 to 11 take instruction fills and lines 12 to 15 take constant-data fills, which caps data at four lines. Each class has its own round-robin victim pointer that skips locked lines. When a prefetch switch is on, a demand fill is followed by a background fetch of the next sequential line. A new demand miss cancels that fetch. A global invalidate clears every valid bit.

Top module: `flash_line_cache`

## Requirements
- R1: After reset `req_ready_o` is 1, and `rsp_valid_o` and `fl_en_o` are 0. No line is valid, so the first access to any address is a miss.
- R2: A request that hits is accepted and its word appears on `rsp_data_o` with `rsp_valid_o` high in the cycle right after the accepting edge. The hit starts no flash access.
- R3: On a miss, `fl_en_o` is high and `fl_line_addr_o` carries the request's line address (word address bits [WA-1:2]) for `cfg_wait_i`+1 cycles, and `req_ready_o` is low. The response follows `cfg_wait_i`+1 edges after acceptance. Word k of the response is taken from bits [32k+31:32k] of `fl_line_i`, where k is word-address bits [1:0].
- R4: A line whose `lock_i` bit is 1 is never chosen as a victim, so a locked valid line keeps hitting through any number of misses.
- R5: Instruction misses (`req_data_i`=0) allocate only in lines 0..11 and data misses (`req_data_i`=1) only in lines 12..15. Each class replaces round-robin from the line after its last victim, starting at its lowest line after reset.
- R6: When every line of the missing class is locked, the word is served from flash without allocation, and a repeat of the same address misses again.
- R7: A 1 in bit i of `cfg_mask_i` excludes line-address bit i from the tag compare. An access that differs from a cached line only in masked bits hits that line and returns that line's contents.
- R8: With `cfg_pf_en_i`=1, a demand fill is followed by a fill of the next line address (+1), unless that line is already present. `req_ready_o` stays high during the prefetch. With `cfg_pf_en_i`=0 no flash access follows a fill, and hits are still served.
- R9: A demand miss accepted during a prefetch cancels it. From the next cycle the flash port carries the demand line, and the cancelled line is not allocated.
- R10: A hit accepted during a prefetch is answered in the next cycle, and the prefetch goes on to complete.
- R11: A one-cycle `inval_i` pulse clears every valid bit and drops a running prefetch, so previously cached addresses miss afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Fetch request valid |
| req_ready_o | output | 1 | Request accepted on this edge when high with valid |
| req_waddr_i | input | ADDR_W-2 | Word address of the fetch |
| req_data_i | input | 1 | 1 = constant-data fetch, 0 = instruction fetch |
| rsp_valid_o | output | 1 | Response word valid, one cycle |
| rsp_data_o | output | 32 | Response word |
| cfg_wait_i | input | WAIT_W | Flash wait states |
| cfg_pf_en_i | input | 1 | Next-line prefetch enable |
| cfg_mask_i | input | ADDR_W-4 | Line-address bits excluded from tag compare |
| lock_i | input | LINES | Per-line replacement lock |
| inval_i | input | 1 | Clear all valid bits |
| fl_en_o | output | 1 | Flash read active |
| fl_line_addr_o | output | ADDR_W-4 | Line address presented to flash |
| fl_line_i | input | LINE_W | Line read from flash |

## Verification
The bench aims at the victim choice. It fills more data lines than the data subset holds, and re-touches them so that a broken round-robin or a missing class split shows up as a hit where a miss belongs, or the reverse. Locked lines are stressed by long runs of misses, and once every line is locked, where a design that ignored locks would evict them or wrongly allocate. Alias hits under a mask must return the stored copy, not fresh flash data. Prefetch is attacked three ways: a demand miss arrives during the background fetch, which a design without demand priority would answer late or with the wrong line; a hit arrives mid-prefetch; and an invalidate lands mid-prefetch, after which a leaky design would leave the prefetched line valid.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam int unsigned WORD_W = 32;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PF   = 2'd2
  } flc_state_e;
endpackage

// File: rtl/flc_tag_match.sv
module flc_tag_match #(
  parameter int unsigned LINES = 16,
  parameter int unsigned TAG_W = 28
) (
  input  logic [LINES-1:0]            valid_i,
  input  logic [LINES-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]            tag_i,
  input  logic [TAG_W-1:0]            mask_i,
  output logic [LINES-1:0]            match_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (((tags_i[g] ^ tag_i) & ~mask_i) == '0);
  end
endmodule

// File: rtl/flc_victim_sel.sv
module flc_victim_sel #(
  parameter int unsigned LINES = 16,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] elig_i,
  input  logic [IDX_W-1:0] start_i,
  output logic [IDX_W-1:0] vic_o,
  output logic             ok_o
);
  // first eligible line at or after start_i, wrapping
  always_comb begin
    logic found;
    logic [IDX_W-1:0] pos;
    found = 1'b0;
    vic_o = '0;
    for (int k = 0; k < LINES; k++) begin
      pos = start_i + IDX_W'(k);
      if (!found && elig_i[pos]) begin
        vic_o = pos;
        found = 1'b1;
      end
    end
  end
  assign ok_o = |elig_i;
endmodule

// File: rtl/flc_line_store.sv
module flc_line_store #(
  parameter int unsigned LINES  = 16,
  parameter int unsigned TAG_W  = 28,
  parameter int unsigned LINE_W = 128,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             widx_i,
  input  logic [TAG_W-1:0]             wtag_i,
  input  logic [LINE_W-1:0]            wdata_i,
  input  logic                         inval_i,
  output logic [LINES-1:0]             valid_o,
  output logic [LINES-1:0][TAG_W-1:0]  tags_o,
  output logic [LINES-1:0][LINE_W-1:0] data_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              v_q;
    logic [TAG_W-1:0]  t_q;
    logic [LINE_W-1:0] d_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        t_q <= '0;
        d_q <= '0;
      end else begin
        if (we_i && widx_i == IDX_W'(g)) begin
          v_q <= 1'b1;
          t_q <= wtag_i;
          d_q <= wdata_i;
        end
        if (inval_i) v_q <= 1'b0; // invalidate wins over a same-cycle fill
      end
    end
    assign valid_o[g] = v_q;
    assign tags_o[g]  = t_q;
    assign data_o[g]  = d_q;
  end
endmodule

// File: rtl/flash_line_cache.sv
module flash_line_cache
  import flc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINES      = 16,
  parameter int unsigned LINE_W     = 128,
  parameter int unsigned DATA_LINES = 4,
  parameter int unsigned WAIT_W     = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [ADDR_W-3:0]     req_waddr_i,
  input  logic                  req_data_i,
  output logic                  rsp_valid_o,
  output logic [WORD_W-1:0]     rsp_data_o,
  input  logic [WAIT_W-1:0]     cfg_wait_i,
  input  logic                  cfg_pf_en_i,
  input  logic [ADDR_W-5:0]     cfg_mask_i,
  input  logic [LINES-1:0]      lock_i,
  input  logic                  inval_i,
  output logic                  fl_en_o,
  output logic [ADDR_W-5:0]     fl_line_addr_o,
  input  logic [LINE_W-1:0]     fl_line_i
);
  localparam int unsigned WORDS  = LINE_W / WORD_W;
  localparam int unsigned WSEL_W = $clog2(WORDS);
  localparam int unsigned TAG_W  = ADDR_W - 4;
  localparam int unsigned IDX_W  = $clog2(LINES);
  localparam logic [LINES-1:0] DMASK = ~({LINES{1'b1}} >> DATA_LINES);

  function automatic logic [WORD_W-1:0] pick(input logic [LINE_W-1:0] ln,
                                             input logic [WSEL_W-1:0] w);
    return ln[WORD_W*w +: WORD_W];
  endfunction

  flc_state_e        state_q;
  logic [WAIT_W-1:0] cnt_q;
  logic [TAG_W-1:0]  ftag_q;
  logic [WSEL_W-1:0] fword_q;
  logic              fdata_q;
  logic [IDX_W-1:0]  rr_i_q, rr_d_q;
  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_data_q;

  logic [LINES-1:0]             valid;
  logic [LINES-1:0][TAG_W-1:0]  tags;
  logic [LINES-1:0][LINE_W-1:0] lines;

  logic [TAG_W-1:0]  req_tag;
  logic [WSEL_W-1:0] req_word;
  assign req_tag  = req_waddr_i[ADDR_W-3:WSEL_W];
  assign req_word = req_waddr_i[WSEL_W-1:0];

  // demand lookup
  logic [LINES-1:0] dmatch;
  logic             hit_d;
  logic [IDX_W-1:0] hidx;
  flc_tag_match #(.LINES(LINES), .TAG_W(TAG_W)) u_match_d (
    .valid_i(valid), .tags_i(tags), .tag_i(req_tag), .mask_i(cfg_mask_i),
    .match_o(dmatch)
  );
  assign hit_d = |dmatch;
  always_comb begin
    hidx = '0;
    for (int i = LINES - 1; i >= 0; i--) if (dmatch[i]) hidx = IDX_W'(i);
  end

  // next-line presence probe
  logic [LINES-1:0] pmatch;
  logic [TAG_W-1:0] ptag;
  assign ptag = ftag_q + TAG_W'(1);
  flc_tag_match #(.LINES(LINES), .TAG_W(TAG_W)) u_match_p (
    .valid_i(valid), .tags_i(tags), .tag_i(ptag), .mask_i(cfg_mask_i),
    .match_o(pmatch)
  );

  // victim choice per class
  logic [IDX_W-1:0] vic_i, vic_d, vic;
  logic             ok_i, ok_d, vic_ok;
  flc_victim_sel #(.LINES(LINES)) u_vic_i (
    .elig_i(~lock_i & ~DMASK), .start_i(rr_i_q), .vic_o(vic_i), .ok_o(ok_i)
  );
  flc_victim_sel #(.LINES(LINES)) u_vic_d (
    .elig_i(~lock_i & DMASK), .start_i(rr_d_q), .vic_o(vic_d), .ok_o(ok_d)
  );
  assign vic    = fdata_q ? vic_d : vic_i;
  assign vic_ok = fdata_q ? ok_d : ok_i;

  logic acc, last, cap_d, cap_p, we, pf_start;
  assign req_ready_o = (state_q != ST_FILL);
  assign acc      = req_valid_i && req_ready_o;
  assign last     = (cnt_q == cfg_wait_i);
  assign cap_d    = (state_q == ST_FILL) && last;
  assign cap_p    = (state_q == ST_PF) && last && !(acc && !hit_d) && !inval_i;
  assign we       = (cap_d || cap_p) && vic_ok;
  assign pf_start = cap_d && cfg_pf_en_i && !(|pmatch) && !inval_i;

  flc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
    .clk_i, .rst_ni, .we_i(we), .widx_i(vic), .wtag_i(ftag_q),
    .wdata_i(fl_line_i), .inval_i, .valid_o(valid), .tags_o(tags), .data_o(lines)
  );

  assign fl_en_o        = (state_q != ST_IDLE);
  assign fl_line_addr_o = ftag_q;
  assign rsp_valid_o    = rsp_valid_q;
  assign rsp_data_o     = rsp_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      ftag_q      <= '0;
      fword_q     <= '0;
      fdata_q     <= 1'b0;
      rr_i_q      <= '0;
      rr_d_q      <= IDX_W'(LINES - DATA_LINES);
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (acc && hit_d) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= pick(lines[hidx], req_word);
      end
      if (cap_d) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= pick(fl_line_i, fword_q);
      end
      if (we) begin
        if (fdata_q) rr_d_q <= vic + IDX_W'(1);
        else         rr_i_q <= vic + IDX_W'(1);
      end
      unique case (state_q)
        ST_FILL: begin
          if (cap_d) begin
            if (pf_start) begin
              state_q <= ST_PF;
              ftag_q  <= ptag;
              cnt_q   <= '0;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + WAIT_W'(1);
          end
        end
        default: begin // idle or prefetch: a demand miss takes the port
          if (acc && !hit_d) begin
            state_q <= ST_FILL;
            ftag_q  <= req_tag;
            fword_q <= req_word;
            fdata_q <= req_data_i;
            cnt_q   <= '0;
          end else if (state_q == ST_PF) begin
            if (inval_i || last) state_q <= ST_IDLE;
            else                 cnt_q   <= cnt_q + WAIT_W'(1);
          end
        end
      endcase
    end
  end

  a_r2_hit_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && hit_d |=> rsp_valid_o);
  a_r2_hit_no_flash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) && acc && hit_d |=> !fl_en_o);
  a_r3_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL) && (cnt_q != '0) |-> $stable(fl_line_addr_o));
  a_r3_fill_answers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_d |=> rsp_valid_o && req_ready_o);
  a_r4_locked_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> !lock_i[vic]);
  a_r5_data_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we && fdata_q |-> int'(vic) >= int'(LINES - DATA_LINES));
  a_r5_instr_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we && !fdata_q |-> int'(vic) < int'(LINES - DATA_LINES));
  a_r9_demand_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PF) && acc && !hit_d |=> fl_en_o && fl_line_addr_o == $past(req_tag));
endmodule

// File: tb/sim_flash_line_cache.sv
`timescale 1ns/1ps
module sim_flash_line_cache;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [29:0]  req_waddr = '0;
  logic         req_data = 1'b0;
  logic         rsp_valid;
  logic [31:0]  rsp_data;
  logic [3:0]   cfg_wait = 4'd2;
  logic         cfg_pf = 1'b0;
  logic [27:0]  cfg_mask = '0;
  logic [15:0]  lock = '0;
  logic         inval = 1'b0;
  logic         fl_en;
  logic [27:0]  fl_laddr;
  logic [127:0] fl_line;

  always #2.5 clk = ~clk;

  flash_line_cache u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_waddr_i(req_waddr), .req_data_i(req_data), .rsp_valid_o(rsp_valid),
    .rsp_data_o(rsp_data), .cfg_wait_i(cfg_wait), .cfg_pf_en_i(cfg_pf),
    .cfg_mask_i(cfg_mask), .lock_i(lock), .inval_i(inval), .fl_en_o(fl_en),
    .fl_line_addr_o(fl_laddr), .fl_line_i(fl_line)
  );

  function automatic logic [31:0] fw(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A3C_00C3;
  endfunction

  // flash model: word k of the line at the presented address
  always_comb
    for (int k = 0; k < 4; k++)
      fl_line[32*k +: 32] = fw({fl_laddr, 4'(k * 4)});

  int total = 0, bad = 0, cyc = 0, fstarts = 0;
  logic        prev_en = 1'b0;
  logic [27:0] prev_addr = '0;
  logic [31:0] q_d[$];
  int          q_acc[$], q_lat[$];
  string       q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // monitor: flash starts and scoreboard compare
  always @(negedge clk) begin
    if (fl_en && (!prev_en || fl_laddr != prev_addr)) fstarts++;
    prev_en   = fl_en;
    prev_addr = fl_laddr;
    if (rsp_valid) begin
      if (q_d.size() == 0) begin
        chk(1'b0, "R2", "unexpected response", rsp_data, 32'h0);
      end else begin
        logic [31:0] ed;
        int ea, el;
        string et;
        ed = q_d.pop_front(); ea = q_acc.pop_front();
        el = q_lat.pop_front(); et = q_tag.pop_front();
        chk(rsp_data == ed, et, "data", rsp_data, ed);
        chk((cyc - ea) == el, et, "latency", 32'(cyc - ea), 32'(el));
      end
    end
  end

  task automatic access(input logic [31:0] a, input bit d, input bit hit,
                        input logic [31:0] ed, input string tag);
    req_waddr = a[31:2];
    req_data  = d;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    q_d.push_back(ed); q_acc.push_back(cyc + 1);
    q_lat.push_back(hit ? 0 : int'(cfg_wait) + 1); q_tag.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic acc_w(input logic [31:0] a, input bit d, input bit hit, input string tag);
    access(a, d, hit, fw(a), tag);
  endtask

  task automatic wait_rsp();
    do begin @(negedge clk); #1; end while (q_d.size() != 0);
  endtask

  task automatic settle();
    do begin @(negedge clk); #1; end while (q_d.size() != 0 || fl_en);
    @(negedge clk); #1;
  endtask

  task automatic pulse_inval();
    @(negedge clk); inval = 1'b1;
    @(negedge clk); inval = 1'b0;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    chk(1'b0, "watchdog", "timeout", 32'(cyc), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
    chk(fl_en == 1'b0, "R1", "fl_en after reset", 32'(fl_en), 32'h0);
    acc_w(32'h104, 0, 0, "R1");
    // R3 flash port during the fill
    chk(fl_en == 1'b1, "R3", "fl_en in fill", 32'(fl_en), 32'h1);
    chk(fl_laddr == 28'h10, "R3", "line address", 32'(fl_laddr), 32'h10);
    chk(req_ready == 1'b0, "R3", "ready in fill", 32'(req_ready), 32'h0);
    settle();

    // R2 hits on the filled line
    f0 = fstarts;
    acc_w(32'h108, 0, 1, "R2");
    acc_w(32'h10C, 0, 1, "R2");
    acc_w(32'h100, 0, 1, "R2");
    settle();
    chk(fstarts == f0, "R2", "flash starts on hits", 32'(fstarts - f0), 32'h0);

    // R3 different wait states
    cfg_wait = 4'd0; acc_w(32'h200, 0, 0, "R3"); settle();
    cfg_wait = 4'd5; acc_w(32'h308, 0, 0, "R3"); settle();
    cfg_wait = 4'd2;

    // R5 data subset of four lines, round robin
    acc_w(32'h1000, 1, 0, "R5");
    acc_w(32'h1010, 1, 0, "R5");
    acc_w(32'h1020, 1, 0, "R5");
    acc_w(32'h1030, 1, 0, "R5");
    acc_w(32'h1000, 1, 1, "R5");
    acc_w(32'h1040, 1, 0, "R5");
    acc_w(32'h1010, 1, 1, "R5");
    acc_w(32'h1004, 1, 0, "R5");
    acc_w(32'h100, 0, 1, "R5");
    acc_w(32'h204, 0, 1, "R5");
    settle();

    // R4 locked line survives twelve instruction misses
    lock = 16'h0001;
    for (int k = 0; k < 12; k++) acc_w(32'h2000 + 32'(k * 16), 0, 0, "R4");
    acc_w(32'h10C, 0, 1, "R4");
    acc_w(32'h2010, 0, 1, "R4");
    settle();

    // R6 all instruction lines locked: no allocation
    lock = 16'h0FFF;
    f0 = fstarts;
    acc_w(32'h5000, 0, 0, "R6");
    acc_w(32'h5004, 0, 0, "R6");
    settle();
    chk(fstarts - f0 == 2, "R6", "flash starts", 32'(fstarts - f0), 32'h2);
    acc_w(32'h6000, 1, 0, "R6");
    acc_w(32'h6000, 1, 1, "R6");
    settle();

    // R7 alias through mask of address bit 12 (mask bit 8)
    lock = '0;
    cfg_mask = 28'h100;
    f0 = fstarts;
    access(32'h1100, 0, 1, fw(32'h100), "R7");
    access(32'h1104, 0, 1, fw(32'h104), "R7");
    settle();
    chk(fstarts == f0, "R7", "flash starts on alias", 32'(fstarts - f0), 32'h0);
    cfg_mask = '0;
    acc_w(32'h1104, 0, 0, "R7");
    settle();

    // R8 next-line prefetch
    cfg_pf = 1'b1;
    f0 = fstarts;
    acc_w(32'h7000, 0, 0, "R8");
    wait_rsp();
    chk(fl_en == 1'b1, "R8", "prefetch active", 32'(fl_en), 32'h1);
    chk(fl_laddr == 28'h701, "R8", "prefetch address", 32'(fl_laddr), 32'h701);
    chk(req_ready == 1'b1, "R8", "ready during prefetch", 32'(req_ready), 32'h1);
    settle();
    acc_w(32'h7014, 0, 1, "R8");
    settle();
    chk(fstarts - f0 == 2, "R8", "flash starts with prefetch", 32'(fstarts - f0), 32'h2);
    cfg_pf = 1'b0;
    acc_w(32'h7050, 0, 0, "R8");
    settle();
    cfg_pf = 1'b1;
    f0 = fstarts;
    acc_w(32'h7040, 0, 0, "R8");
    settle();
    chk(fstarts - f0 == 1, "R8", "prefetch skipped if present", 32'(fstarts - f0), 32'h1);
    cfg_pf = 1'b0;
    f0 = fstarts;
    acc_w(32'h7100, 0, 0, "R8");
    settle();
    chk(fstarts - f0 == 1, "R8", "no prefetch when off", 32'(fstarts - f0), 32'h1);
    acc_w(32'h7108, 0, 1, "R8");
    settle();

    // R9 demand miss cancels prefetch
    cfg_pf = 1'b1; cfg_wait = 4'd5;
    acc_w(32'h8000, 0, 0, "R9");
    wait_rsp();
    acc_w(32'h9000, 0, 0, "R9");
    chk(fl_laddr == 28'h900, "R9", "demand takes port", 32'(fl_laddr), 32'h900);
    chk(req_ready == 1'b0, "R9", "demand fill busy", 32'(req_ready), 32'h0);
    settle();
    acc_w(32'h8010, 0, 0, "R9");
    settle();

    // R10 hit during prefetch
    acc_w(32'hA000, 0, 0, "R10");
    wait_rsp();
    acc_w(32'h8018, 0, 1, "R10");
    chk(fl_en == 1'b1 && fl_laddr == 28'hA01, "R10", "prefetch continues",
        32'(fl_laddr), 32'hA01);
    settle();
    acc_w(32'hA010, 0, 1, "R10");
    settle();

    // R11 invalidate
    cfg_pf = 1'b0; cfg_wait = 4'd2;
    pulse_inval();
    settle();
    acc_w(32'h8010, 0, 0, "R11");
    acc_w(32'hA010, 0, 0, "R11");
    settle();
    cfg_pf = 1'b1; cfg_wait = 4'd5;
    acc_w(32'hB000, 0, 0, "R11");
    wait_rsp();
    pulse_inval();
    settle();
    cfg_pf = 1'b0;
    acc_w(32'hB010, 0, 0, "R11");
    acc_w(32'hB000, 0, 0, "R11");
    settle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule